// File: doc/BRIEF.md
# Fully Associative Branch History Table

This block sits beside the fetch stage and predicts, in the same cycle as the fetch, where the next instruction comes from. It keeps a small set of entries. Each entry holds a valid flag, the full address of a branch instruction used as the tag, the address that branch jumped to, and a 2-bit saturating confidence counter. The current fetch address is compared against every valid tag at once. When an entry matches and its counter leans towards taken, the stored target becomes the next fetch address. In every other case fetch simply moves on to the next sequential word, the fetch address plus 4.

The resolution stage reports every resolved branch on the update port, giving its address, its real target and whether it was taken. A branch already in the table has its counter trained and its target rewritten. A taken branch that is not in the table gets a new entry. The entry used is the lowest-numbered empty one, or, once the table is full, the entry under a round-robin pointer. A synchronous flush empties the table in a single cycle. The number of entries and the address width are parameters.

Top module: `branch_hist_table`

## Requirements
- R1: After reset every entry is empty. Every lookup misses, so `lookupHit`=0, `predTaken`=0 and `nextPc`=`fetchPc`+4.
- R2: A lookup compares `fetchPc` against the tags of all valid entries within the same cycle and needs no clock edge. At most one entry ever matches a given address.
- R3: On a hit, `lookupHit`=1. A counter value of 2 or 3 gives `predTaken`=1 and `nextPc` = the stored target. A counter value of 0 or 1 gives `predTaken`=0 and `nextPc`=`fetchPc`+4.
- R4: A resolved branch that hits the table trains its counter. A taken outcome adds 1, saturating at 3. A not-taken outcome subtracts 1, saturating at 0.
- R5: On a miss, `predTaken`=0 and `nextPc`=`fetchPc`+4, computed modulo 2^ADDR_W.
- R6: A resolved taken branch that misses is allocated an entry with its counter set to 2 and its target stored. If any entry is empty, the lowest-numbered empty entry is chosen.
- R7: When the table is full, the victim is the entry under a round-robin pointer. The pointer starts at entry 0 and advances by one, wrapping, only each time it supplies a victim.
- R8: A resolved not-taken branch that misses allocates nothing, and no table entry changes.
- R9: A resolved branch that hits has its stored target replaced by the reported target, whether or not it was taken.
- R10: An update takes effect at the next clock edge. A lookup in the same cycle sees the contents from before the update, including for the same address.
- R11: `flush` empties every entry at the next edge and returns the round-robin pointer to entry 0. An update presented in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | ADDR_W | Address being fetched this cycle |
| lookupHit | output | 1 | Fetch address matches a valid entry |
| predTaken | output | 1 | Branch at fetchPc predicted taken |
| nextPc | output | ADDR_W | Predicted next fetch address |
| updValid | input | 1 | A resolved branch is reported this cycle |
| updPc | input | ADDR_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| updTarget | input | ADDR_W | Resolved target address of the branch |
| flush | input | 1 | Empty the whole table at the next edge |

## Verification
Every cycle, the assertions check the following. At most one entry matches the fetch address. A miss always falls through to the sequential address. A freshly allocated entry comes up valid with counter 2 and the right tag. A trained counter moves only in the direction of the outcome. A flush leaves no valid entry. Allocation always lands on an empty slot while one exists. Some behaviours can only be shown by the bench's scenarios, which replay a stream of updates against an arithmetic model: the exact victim order once the table is full, the pointer resetting on flush, pre-update visibility for same-cycle lookups, and saturation at both ends of the counter.

// File: rtl/branch_hist_pkg.sv
package branch_hist_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic write;   // write the entry selected by wrIdx
    logic alloc;   // write is a fresh allocation (else a training update)
    logic clear;   // drop every valid bit
  } bhStrobe_t;

  localparam logic [1:0] CTR_ALLOC = 2'd2;

  function automatic logic [1:0] ctrTrain(input logic [1:0] ctr, input logic taken);
    logic [1:0] res;
    if (taken) res = (ctr == 2'd3) ? ctr : ctr + 2'd1;
    else       res = (ctr == 2'd0) ? ctr : ctr - 2'd1;
    return res;
  endfunction

  function automatic logic ctrPredicts(input logic [1:0] ctr);
    return ctr[1];
  endfunction

endpackage

// File: rtl/branch_hist_datapath.sv
module branch_hist_datapath
  import branch_hist_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      fetchPc,
  output logic                   lookupHit,
  output logic                   predTaken,
  output logic [ADDR_W-1:0]      nextPc,
  input  logic [ADDR_W-1:0]      updPc,
  input  logic                   updTaken,
  input  logic [ADDR_W-1:0]      updTarget,
  input  bhStrobe_t              stb,
  input  logic [IDX_W-1:0]       wrIdx,
  output logic                   updHit,
  output logic [IDX_W-1:0]       updHitIdx,
  output logic [NUM_ENTRIES-1:0] validVec
);

  logic [NUM_ENTRIES-1:0] validQ;
  logic [ADDR_W-1:0]      tagQ [NUM_ENTRIES];
  logic [ADDR_W-1:0]      tgtQ [NUM_ENTRIES];
  logic [1:0]             ctrQ [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] lkHitVec;
  logic [NUM_ENTRIES-1:0] upHitVec;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ENTRIES; gi++) begin : gEntry
      assign lkHitVec[gi] = validQ[gi] && (tagQ[gi] == fetchPc);
      assign upHitVec[gi] = validQ[gi] && (tagQ[gi] == updPc);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ[gi] <= 1'b0;
          tagQ[gi]   <= '0;
          tgtQ[gi]   <= '0;
          ctrQ[gi]   <= '0;
        end else if (stb.clear) begin
          validQ[gi] <= 1'b0;
        end else if (stb.write && (wrIdx == IDX_W'(gi))) begin
          validQ[gi] <= 1'b1;
          tagQ[gi]   <= updPc;
          tgtQ[gi]   <= updTarget;
          ctrQ[gi]   <= stb.alloc ? CTR_ALLOC : ctrTrain(ctrQ[gi], updTaken);
        end
      end

      AST_ALLOC_INIT: assert property (@(posedge clk) disable iff (!rstN)
        (stb.write && stb.alloc && !stb.clear && wrIdx == IDX_W'(gi))
        |=> (validQ[gi] && ctrQ[gi] == CTR_ALLOC && tagQ[gi] == $past(updPc))); // R6

      AST_CTR_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
        (stb.write && !stb.alloc && !stb.clear && wrIdx == IDX_W'(gi))
        |=> ($past(updTaken) ? (ctrQ[gi] >= $past(ctrQ[gi]))
                             : (ctrQ[gi] <= $past(ctrQ[gi])))); // R4
    end
  endgenerate

  // One-hot selects collapse to an OR tree
  logic [ADDR_W-1:0] selTgt;
  logic [1:0]        selCtr;
  logic [ADDR_W-1:0] seqPc;

  always_comb begin
    selTgt    = '0;
    selCtr    = '0;
    updHitIdx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      selTgt    = selTgt | ({ADDR_W{lkHitVec[i]}} & tgtQ[i]);
      selCtr    = selCtr | ({2{lkHitVec[i]}} & ctrQ[i]);
      updHitIdx = updHitIdx | ({IDX_W{upHitVec[i]}} & IDX_W'(i));
    end
  end

  assign seqPc     = fetchPc + ADDR_W'(4);
  assign lookupHit = |lkHitVec;
  assign predTaken = lookupHit && ctrPredicts(selCtr);
  assign nextPc    = predTaken ? selTgt : seqPc;
  assign updHit    = |upHitVec;
  assign validVec  = validQ;

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkHitVec)); // R2

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> (!predTaken && nextPc == fetchPc + ADDR_W'(4))); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (validQ == '0)); // R11

endmodule

// File: rtl/branch_hist_control.sv
module branch_hist_control
  import branch_hist_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   updValid,
  input  logic                   updTaken,
  input  logic                   flush,
  input  logic                   updHit,
  input  logic [IDX_W-1:0]       updHitIdx,
  input  logic [NUM_ENTRIES-1:0] validVec,
  output bhStrobe_t              stb,
  output logic [IDX_W-1:0]       wrIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic             anyFree;

  // Lowest-numbered empty entry wins
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  always_comb begin
    stb.clear = flush;
    stb.write = updValid && !flush && (updHit || updTaken);
    stb.alloc = !updHit;
    if (updHit)       wrIdx = updHitIdx;
    else if (anyFree) wrIdx = freeIdx;
    else              wrIdx = rrPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (flush) begin
      rrPtr <= '0;
    end else if (stb.write && stb.alloc && !anyFree) begin
      rrPtr <= (rrPtr == LAST_IDX) ? '0 : rrPtr + IDX_W'(1);
    end
  end

  AST_VICTIM_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.write && stb.alloc && anyFree) |-> !validVec[wrIdx]); // R6

  AST_NOTTAKEN_NOALLOC: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken && !updHit) |-> !stb.write); // R8

  AST_FLUSH_DROPS_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !stb.write); // R11

endmodule

// File: rtl/branch_hist_table.sv
module branch_hist_table
  import branch_hist_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] fetchPc,
  output logic              lookupHit,
  output logic              predTaken,
  output logic [ADDR_W-1:0] nextPc,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updPc,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget,
  input  logic              flush
);

  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  bhStrobe_t              stb;
  logic [IDX_W-1:0]       wrIdx;
  logic                   updHit;
  logic [IDX_W-1:0]       updHitIdx;
  logic [NUM_ENTRIES-1:0] validVec;

  branch_hist_control #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .updValid (updValid),
    .updTaken (updTaken),
    .flush    (flush),
    .updHit   (updHit),
    .updHitIdx(updHitIdx),
    .validVec (validVec),
    .stb      (stb),
    .wrIdx    (wrIdx)
  );

  branch_hist_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .fetchPc  (fetchPc),
    .lookupHit(lookupHit),
    .predTaken(predTaken),
    .nextPc   (nextPc),
    .updPc    (updPc),
    .updTaken (updTaken),
    .updTarget(updTarget),
    .stb      (stb),
    .wrIdx    (wrIdx),
    .updHit   (updHit),
    .updHitIdx(updHitIdx),
    .validVec (validVec)
  );

endmodule

// File: tb/branch_hist_table_test.sv
module branch_hist_table_test;
  localparam int N  = 4;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] fetchPc = '0;
  logic          lookupHit;
  logic          predTaken;
  logic [AW-1:0] nextPc;
  logic          updValid = 1'b0;
  logic [AW-1:0] updPc = '0;
  logic          updTaken = 1'b0;
  logic [AW-1:0] updTarget = '0;
  logic          flush = 1'b0;

  always #10 clk = ~clk;

  branch_hist_table #(.NUM_ENTRIES(N), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .fetchPc(fetchPc), .lookupHit(lookupHit),
    .predTaken(predTaken), .nextPc(nextPc), .updValid(updValid), .updPc(updPc),
    .updTaken(updTaken), .updTarget(updTarget), .flush(flush)
  );

  // Model built from the requirements
  logic          mValid [N];
  logic [AW-1:0] mTag [N];
  logic [AW-1:0] mTgt [N];
  logic [1:0]    mCtr [N];
  int            mRr;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mValid[i] = 1'b0; mTag[i] = '0; mTgt[i] = '0; mCtr[i] = '0;
    end
    mRr = 0;
  endtask

  task automatic modelApply(input logic uv, input logic [AW-1:0] upc,
                            input logic ut, input logic [AW-1:0] utg, input logic fl);
    int hitIdx;
    int freeIdx;
    hitIdx = -1;
    freeIdx = -1;
    if (fl) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
      mRr = 0;
    end else if (uv) begin
      for (int i = 0; i < N; i++) if (mValid[i] && mTag[i] == upc) hitIdx = i;
      if (hitIdx >= 0) begin
        if (ut) mCtr[hitIdx] = (mCtr[hitIdx] == 2'd3) ? 2'd3 : mCtr[hitIdx] + 2'd1;
        else    mCtr[hitIdx] = (mCtr[hitIdx] == 2'd0) ? 2'd0 : mCtr[hitIdx] - 2'd1;
        mTgt[hitIdx] = utg;
      end else if (ut) begin
        for (int i = N - 1; i >= 0; i--) if (!mValid[i]) freeIdx = i;
        if (freeIdx < 0) begin
          freeIdx = mRr;
          mRr = (mRr + 1) % N;
        end
        mValid[freeIdx] = 1'b1; mTag[freeIdx] = upc;
        mTgt[freeIdx] = utg;    mCtr[freeIdx] = 2'd2;
      end
    end
  endtask

  // Drive one cycle, check the lookup before the edge, then advance the model
  task automatic step(input string req, input logic uv, input logic [AW-1:0] upc,
                      input logic ut, input logic [AW-1:0] utg, input logic fl,
                      input logic [AW-1:0] lpc);
    logic eHit;
    logic ePt;
    logic [AW-1:0] eNext;
    @(negedge clk);
    updValid = uv; updPc = upc; updTaken = ut; updTarget = utg; flush = fl;
    fetchPc = lpc;
    #1;
    eHit = 1'b0; ePt = 1'b0; eNext = lpc + AW'(4);
    for (int i = 0; i < N; i++) begin
      if (mValid[i] && mTag[i] == lpc) begin
        eHit = 1'b1;
        if (mCtr[i][1]) begin ePt = 1'b1; eNext = mTgt[i]; end
      end
    end
    check(req, "lookupHit", AW'(lookupHit), AW'(eHit));
    check(req, "predTaken", AW'(predTaken), AW'(ePt));
    check(req, "nextPc", nextPc, eNext);
    @(posedge clk);
    modelApply(uv, upc, ut, utg, fl);
  endtask

  task automatic probe(input string req, input logic [AW-1:0] lpc);
    step(req, 1'b0, '0, 1'b0, '0, 1'b0, lpc);
  endtask

  task automatic upd(input string req, input logic [AW-1:0] upc, input logic ut,
                     input logic [AW-1:0] utg);
    step(req, 1'b1, upc, ut, utg, 1'b0, upc);
  endtask

  localparam logic [AW-1:0] PA = 16'h1000, PB = 16'h1040, PC = 16'h1080,
                            PD = 16'h10C0, PE = 16'h1100, PF = 16'h1140,
                            PG = 16'h1180;

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: empty after reset; R5 wrap of sequential address
    probe("R1", PA);
    probe("R1", 16'h0000);
    probe("R5", 16'hFFFC);

    // R8: not-taken miss allocates nothing
    upd("R8", PA, 1'b0, 16'h2000);
    probe("R8", PA);

    // R10: same-cycle lookup of the allocating branch still misses
    upd("R10", PA, 1'b1, 16'h2000);
    // R6: fresh entry predicts taken with counter 2
    probe("R6", PA);

    // R4/R3: walk the counter down to 0 and back up to 3, saturating
    upd("R4", PA, 1'b0, 16'h2000);  probe("R3", PA);   // 1 -> not taken, hit
    upd("R4", PA, 1'b0, 16'h2000);  probe("R4", PA);   // 0
    upd("R4", PA, 1'b0, 16'h2000);  probe("R4", PA);   // stays 0
    upd("R4", PA, 1'b1, 16'h2000);  probe("R4", PA);   // 1
    upd("R4", PA, 1'b1, 16'h2000);  probe("R3", PA);   // 2 taken
    upd("R4", PA, 1'b1, 16'h2000);                     // 3
    upd("R4", PA, 1'b1, 16'h2000);                     // stays 3
    upd("R4", PA, 1'b0, 16'h2000);  probe("R4", PA);   // 2 still taken

    // R9: target rewritten on a hit, also on a not-taken outcome
    upd("R9", PA, 1'b1, 16'h2400);  probe("R9", PA);   // 3, new target
    upd("R9", PA, 1'b0, 16'h2800);  probe("R9", PA);   // 2, new target

    // R6: fill remaining empty entries in order
    upd("R6", PB, 1'b1, 16'h3000);
    upd("R6", PC, 1'b1, 16'h3100);
    upd("R6", PD, 1'b1, 16'h3200);
    probe("R6", PB); probe("R6", PC); probe("R6", PD);

    // R7: full table, round-robin victims start at entry 0
    upd("R7", PE, 1'b1, 16'h3300);
    probe("R7", PA); probe("R7", PE);
    upd("R7", PF, 1'b1, 16'h3400);
    probe("R7", PB); probe("R7", PF);

    // R11: flush clears all and drops a same-cycle update
    step("R11", 1'b1, PG, 1'b1, 16'h3500, 1'b1, PE);
    probe("R11", PE); probe("R11", PG); probe("R11", PC);

    // R11/R7: pointer back at entry 0 after flush
    upd("R11", PA, 1'b1, 16'h4000);
    upd("R11", PB, 1'b1, 16'h4100);
    upd("R11", PC, 1'b1, 16'h4200);
    upd("R11", PD, 1'b1, 16'h4300);
    upd("R7", PE, 1'b1, 16'h4400);
    probe("R7", PA); probe("R7", PB);

    // R2: long pseudo-random stream over a small address pool
    lfsr = 16'hACE1;
    for (int it = 0; it < 600; it++) begin
      logic [AW-1:0] upc;
      logic [AW-1:0] lpc;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      upc = 16'h1000 + AW'({lfsr[2:0], 6'b0});
      lpc = lfsr[5] ? upc : 16'h1000 + AW'({lfsr[8:6], 6'b0});
      step("R2", lfsr[9] | lfsr[4], upc, lfsr[11] | lfsr[3],
           {lfsr[15:4], 4'b0}, (it % 97) == 96, lpc);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule